// File: doc/BRIEF.md
# At-Speed Delay Test Sequencer

This block drives a full-scan delay test on a design that has no hold latches. It sets the scan enable and chooses, cycle by cycle, whether the tester's slow shift pulse or the rated-speed pulse reaches the scan flops. It also drives the primary inputs and marks the cycle in which the response is captured. Two launch styles are offered. In shift-launch mode the second vector is made by one more scan shift of the first vector. In capture-launch mode the second vector's state bits come from the logic's own response to the first vector, through a functional pulse.

Software, or a tester, sets up the mode, the chain length and the two primary-input vectors, then pulses a start strobe. The block fills the scan chain and performs the launch and the capture. It then empties the chain and raises a done flag. The scan chain, the logic under test and the clock generation all sit outside the block. The block has one state step per cycle of its own clock, and the two pulse enables tell the clock generator which pulse to send in that step.

Top module: `atspeed_seq`

## Requirements
- R1: After reset, test_ctl_o is 1 (functional mode), slow_pls_o, rated_pls_o, capture_o and done_o are 0, and pi_o is all zeros.
- R2: A start_i seen high at a clock edge while idle or done begins a fill of N cycles, with N equal to chain_len_i, or 1 when chain_len_i is 0. During these cycles test_ctl_o is 0, slow_pls_o is 1 and pi_o shows the first vector.
- R3: With mode_i = 0 (shift launch), the cycle after the fill has slow_pls_o = 1, test_ctl_o = 0 and pi_o switched to the second vector. In the next cycle test_ctl_o is 1, rated_pls_o is 1 and capture_o is 1.
- R4: With mode_i = 1 (capture launch), the cycle after the fill has test_ctl_o = 1, rated_pls_o = 1, capture_o = 0 and pi_o on the second vector. In the next cycle rated_pls_o and capture_o are both 1, so capture comes exactly one rated pulse after launch.
- R5: After capture, N unload cycles follow with test_ctl_o = 0, slow_pls_o = 1 and pi_o holding the second vector. The cycle after that, done_o rises with test_ctl_o = 1 and no pulses, and it holds until the next start.
- R6: slow_pls_o and rated_pls_o are never 1 in the same cycle.
- R7: mode_i, chain_len_i and both vectors are sampled only on an accepted start. Changes to them during a run have no effect on that run.
- R8: start_i while a run is in progress is ignored, and the run's timing is unchanged.
- R9: chain_len_i = 0 behaves exactly as chain_len_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, one step per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| mode_i | input | 1 | 0 = shift launch, 1 = capture launch |
| chain_len_i | input | LEN_W | Scan chain length in shifts |
| pi_v1_i | input | PI_W | Primary inputs for the first vector |
| pi_v2_i | input | PI_W | Primary inputs for the second vector |
| test_ctl_o | output | 1 | 0 = scan mode, 1 = functional mode |
| slow_pls_o | output | 1 | Request a slow shift pulse this cycle |
| rated_pls_o | output | 1 | Request a rated-speed pulse this cycle |
| pi_o | output | PI_W | Primary-input drive |
| capture_o | output | 1 | Response capture cycle |
| done_o | output | 1 | Run complete, held until next start |

## Verification
The bench sweeps both modes over every chain length, including zero and the maximum. It compares every output in every cycle against a schedule computed from the requirements. A design that kept scan enable low for the rated capture, swapped the pulse kinds at launch, or applied the second vector one cycle late breaks the per-cycle comparison at launch or capture. Mid-run changes to the start, mode, length and vector inputs catch a sequencer that resamples its configuration or restarts, because either fault stretches or reshapes the schedule. A counter that is off by one, or that treats a length of zero as zero shifts, moves the launch and done cycles.

// File: rtl/atspeed_pkg.sv
package atspeed_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAUNCH,
    ST_CAPT,
    ST_UNLOAD,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/atspeed_cnt.sv
module atspeed_cnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] ld_val;

  // zero length treated as a single shift
  assign ld_val = (len_i == '0) ? LEN_W'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= ld_val;
    else if (dec_i)  cnt_q <= cnt_q - LEN_W'(1);
  end

  assign last_o = (cnt_q == LEN_W'(1));

  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/atspeed_fsm.sv
module atspeed_fsm
  import atspeed_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       cnt_load_o,
  output logic       cnt_dec_o
);
  seq_state_e st_q, st_d;

  assign accept_o   = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign cnt_load_o = accept_o || (st_q == ST_CAPT);
  assign cnt_dec_o  = (st_q == ST_LOAD) || (st_q == ST_UNLOAD);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (accept_o) st_d = ST_LOAD;
      ST_LOAD:          if (last_i) st_d = ST_LAUNCH;
      ST_LAUNCH:        st_d = ST_CAPT;
      ST_CAPT:          st_d = ST_UNLOAD;
      ST_UNLOAD:        if (last_i) st_d = ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  assert_launch_then_capt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LAUNCH) |=> (st_q == ST_CAPT));
  assert_ignore_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UNLOAD && !last_i) |=> (st_q == ST_UNLOAD));
endmodule

// File: rtl/atspeed_dec.sv
module atspeed_dec
  import atspeed_pkg::*;
#(
  parameter int PI_W = 8
) (
  input  seq_state_e      state_i,
  input  logic            loc_mode_i,
  input  logic [PI_W-1:0] v1_i,
  input  logic [PI_W-1:0] v2_i,
  output logic            test_ctl_o,
  output logic            slow_pls_o,
  output logic            rated_pls_o,
  output logic            capture_o,
  output logic            done_o,
  output logic [PI_W-1:0] pi_o
);
  always_comb begin
    test_ctl_o  = 1'b1;
    slow_pls_o  = 1'b0;
    rated_pls_o = 1'b0;
    capture_o   = 1'b0;
    done_o      = 1'b0;
    pi_o        = v2_i;
    unique case (state_i)
      ST_IDLE: pi_o = v1_i;
      ST_LOAD: begin
        test_ctl_o = 1'b0;
        slow_pls_o = 1'b1;
        pi_o       = v1_i;
      end
      ST_LAUNCH: begin
        test_ctl_o  = loc_mode_i;
        slow_pls_o  = !loc_mode_i;
        rated_pls_o = loc_mode_i;
      end
      ST_CAPT: begin
        rated_pls_o = 1'b1;
        capture_o   = 1'b1;
      end
      ST_UNLOAD: begin
        test_ctl_o = 1'b0;
        slow_pls_o = 1'b1;
      end
      ST_DONE: done_o = 1'b1;
      default: pi_o = v1_i;
    endcase
  end
endmodule

// File: rtl/atspeed_seq.sv
module atspeed_seq
  import atspeed_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int PI_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] chain_len_i,
  input  logic [PI_W-1:0]  pi_v1_i,
  input  logic [PI_W-1:0]  pi_v2_i,
  output logic             test_ctl_o,
  output logic             slow_pls_o,
  output logic             rated_pls_o,
  output logic [PI_W-1:0]  pi_o,
  output logic             capture_o,
  output logic             done_o
);
  seq_state_e       state;
  logic             accept, cnt_load, cnt_dec, cnt_last;
  logic             mode_q;
  logic [LEN_W-1:0] len_q, cnt_len;
  logic [PI_W-1:0]  v1_q, v2_q;
  logic             busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      len_q  <= '0;
      v1_q   <= '0;
      v2_q   <= '0;
    end else if (accept) begin
      mode_q <= mode_i;
      len_q  <= chain_len_i;
      v1_q   <= pi_v1_i;
      v2_q   <= pi_v2_i;
    end
  end

  assign cnt_len = accept ? chain_len_i : len_q;
  assign busy    = (state != ST_IDLE) && (state != ST_DONE);

  atspeed_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_i     (cnt_last),
    .state_o    (state),
    .accept_o   (accept),
    .cnt_load_o (cnt_load),
    .cnt_dec_o  (cnt_dec)
  );

  atspeed_cnt #(.LEN_W(LEN_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .dec_i  (cnt_dec),
    .len_i  (cnt_len),
    .last_o (cnt_last)
  );

  atspeed_dec #(.PI_W(PI_W)) i_dec (
    .state_i     (state),
    .loc_mode_i  (mode_q),
    .v1_i        (v1_q),
    .v2_i        (v2_q),
    .test_ctl_o  (test_ctl_o),
    .slow_pls_o  (slow_pls_o),
    .rated_pls_o (rated_pls_o),
    .capture_o   (capture_o),
    .done_o      (done_o),
    .pi_o        (pi_o)
  );

  assert_pulse_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slow_pls_o && rated_pls_o));
  assert_shift_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !mode_q) |-> $past(slow_pls_o && !test_ctl_o));
  assert_func_launch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && mode_q) |-> $past(rated_pls_o && test_ctl_o));
  assert_done_after_unload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(slow_pls_o && !test_ctl_o));
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(v2_q) && $stable(len_q)));
endmodule

// File: tb/test_atspeed_seq.sv
module test_atspeed_seq;
  localparam int LEN_W = 4;
  localparam int PI_W  = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [LEN_W-1:0] chain_len_i = '0;
  logic [PI_W-1:0]  pi_v1_i = '0;
  logic [PI_W-1:0]  pi_v2_i = '0;
  logic             test_ctl_o, slow_pls_o, rated_pls_o, capture_o, done_o;
  logic [PI_W-1:0]  pi_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  atspeed_seq #(.LEN_W(LEN_W), .PI_W(PI_W)) i_atspeed_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .chain_len_i(chain_len_i), .pi_v1_i(pi_v1_i), .pi_v2_i(pi_v2_i),
    .test_ctl_o(test_ctl_o), .slow_pls_o(slow_pls_o), .rated_pls_o(rated_pls_o),
    .pi_o(pi_o), .capture_o(capture_o), .done_o(done_o)
  );

  // packed: {tc, slow, rated, capture, done, pi}
  function automatic logic [PI_W+4:0] observed();
    return {test_ctl_o, slow_pls_o, rated_pls_o, capture_o, done_o, pi_o};
  endfunction

  task automatic check(input string req, input logic [PI_W+4:0] exp_v);
    n_chk++;
    if (observed() !== exp_v) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, observed(), exp_v);
    end
  endtask

  task automatic run(input logic m, input int len);
    logic [PI_W-1:0] v1, v2;
    int n, last_k;
    v1 = PI_W'($urandom);
    v2 = PI_W'($urandom);
    n  = (len == 0) ? 1 : len;  // R9
    last_k = 2 * n + 5;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; chain_len_i = LEN_W'(len);
    pi_v1_i = v1; pi_v2_i = v2;
    for (int k = 1; k <= last_k; k++) begin
      logic [PI_W+4:0] e;
      string tag;
      @(negedge clk_i);
      start_i = 1'b0;
      if (k <= n) begin
        e = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, v1}; tag = (len == 0) ? "R9 fill" : "R2 fill";
      end else if (k == n + 1) begin
        e = m ? {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, v2} : {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, v2};
        tag = m ? "R4 launch" : "R3 launch";
      end else if (k == n + 2) begin
        e = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, v2}; tag = m ? "R4 capture" : "R3 capture";
      end else if (k <= 2 * n + 2) begin
        e = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, v2}; tag = "R5 unload";
      end else begin
        e = {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, v2}; tag = "R5 done";
      end
      check(tag, e);
      if (k == 2) begin
        // R7 R8: disturb every input mid-run, including a start strobe
        start_i = 1'b1; mode_i = ~m; chain_len_i = ~LEN_W'(len);
        pi_v1_i = ~v1; pi_v2_i = ~v2;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, {PI_W{1'b0}}});
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle", {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, {PI_W{1'b0}}});
    for (int m = 0; m < 2; m++)
      for (int len = 0; len < (1 << LEN_W); len++)
        run(m[0], len);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired cyc=%0d actual=running expected=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule